// File: doc/BRIEF.md
# Image Byte Transmit Controller

The controller moves a run of image bytes out of a synchronous SRAM and hands them to a 10-bit parallel serializer, one word per clock. The host issues a start pulse together with a byte count. The block then walks the SRAM from address zero. It puts a read address out one cycle ahead of the returning data, so the one-cycle read latency adds no gap between words. Each returned byte gets two tag bits on top. These mark whether the byte opens the transfer, which is the head of an image frame, or belongs to its body.

The transmit clock pin and the receive clock pin are both driven straight from the controller clock. This keeps the serializer and the far-end deserializer at one common frequency. With a 20 MHz clock the default 18-bit address covers a whole 512×512 one-byte-per-pixel frame in a single command. A busy level marks the transfer. A one-cycle done pulse marks its end.

Top module: `img_tx_ctrl`

## Requirements
- R1: After reset, busy, done, sram_re and ser_valid are low and ser_data is zero.
- R2: A start pulse seen while busy is low and with a non-zero count raises busy in the next cycle. In that same cycle sram_re is high and sram_addr is zero.
- R3: sram_re stays high for exactly count consecutive cycles. sram_addr rises by one in each of these cycles and wraps modulo 2^ADDR_W.
- R4: Each output word carries the SRAM byte in bits [7:0] and a tag in bits [9:8]. The tag is 2'b10 on the first word of a transfer and 2'b01 on every other word.
- R5: The word for the byte read at address step k appears with ser_valid high two cycles after that address was issued. Exactly count words come out back to back, with no idle cycle between them.
- R6: done is high for exactly one cycle, the cycle after the last word. busy falls in that same cycle.
- R7: A start pulse that arrives while busy is high is ignored. The address sequence, the word count and the done timing of the running transfer are unchanged.
- R8: A start pulse with a count of zero is ignored: busy stays low and no read is issued.
- R9: tx_clk and rx_clk both follow the controller clock at every instant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (20 MHz in the target system) |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | One-cycle request to begin a transfer |
| cmd_count | input | ADDR_W+1 | Number of bytes to send |
| sram_addr | output | ADDR_W | SRAM read address |
| sram_re | output | 1 | SRAM read enable |
| sram_rdata | input | DATA_W | SRAM read data, valid one cycle after the address |
| ser_data | output | DATA_W+2 | Tagged word toward the serializer |
| ser_valid | output | 1 | ser_data holds a new word this cycle |
| tx_clk | output | 1 | Serializer clock, same as clk |
| rx_clk | output | 1 | Deserializer clock, same as clk |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench builds the block with ADDR_W=6, which gives a 64-byte SRAM model and counts up to 127. With that setting a single command can read the whole memory and then wrap past its top address. The maximum count also fits in a short run. The one-byte and two-byte transfers bring the head tag, the final tag and the done pulse into adjacent cycles. A start pulse injected in mid-transfer and a zero-count start exercise the two ignore rules.

// File: rtl/img_tx_pkg.sv
package img_tx_pkg;
  localparam int TAG_W = 2;
  localparam logic [TAG_W-1:0] TAG_HEAD = 2'b10;
  localparam logic [TAG_W-1:0] TAG_BODY = 2'b01;

  // tag for a word: head of transfer or body
  function automatic logic [TAG_W-1:0] tag_of(input logic head);
    return head ? TAG_HEAD : TAG_BODY;
  endfunction

  // true when a start request is to be taken
  function automatic logic take_start(input logic start, input logic busy,
                                      input logic cnt_zero);
    return start && !busy && !cnt_zero;
  endfunction
endpackage

// File: rtl/img_tx_rdseq.sv
module img_tx_rdseq #(
  parameter int ADDR_W = 18,
  localparam int CNT_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] addr,
  output logic              re,
  output logic              issue_first,
  output logic              issue_last
);
  logic [CNT_W-1:0] left_q;
  logic             first_q;

  assign issue_first = re && first_q;
  assign issue_last  = re && (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      re      <= 1'b0;
      left_q  <= '0;
      first_q <= 1'b0;
    end else if (go) begin
      addr    <= '0;
      re      <= 1'b1;
      left_q  <= count - 1'b1;
      first_q <= 1'b1;
    end else if (re) begin
      first_q <= 1'b0;
      if (left_q == '0) begin
        re <= 1'b0;
      end else begin
        addr   <= addr + 1'b1;
        left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/img_tx_fmt.sv
module img_tx_fmt
  import img_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int WORD_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_v,
  input  logic              ret_first,
  input  logic              ret_last,
  input  logic [DATA_W-1:0] rdata,
  output logic [WORD_W-1:0] word,
  output logic              word_v,
  output logic              word_last
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word      <= '0;
      word_v    <= 1'b0;
      word_last <= 1'b0;
    end else begin
      word_v    <= ret_v;
      word_last <= ret_v && ret_last;
      if (ret_v) word <= {tag_of(ret_first), rdata};
    end
  end
endmodule

// File: rtl/img_tx_ctrl.sv
module img_tx_ctrl
  import img_tx_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  localparam int CNT_W  = ADDR_W + 1,
  localparam int WORD_W = DATA_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [CNT_W-1:0]  cmd_count,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_re,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic [WORD_W-1:0] ser_data,
  output logic              ser_valid,
  output logic              tx_clk,
  output logic              rx_clk,
  output logic              busy,
  output logic              done
);
  // named internal events
  logic accept;
  logic issue_first, issue_last;
  logic ret_v, ret_first, ret_last;
  logic word_last;

  assign accept = take_start(cmd_start, busy, cmd_count == '0);

  // one shared clock to both ends of the link
  assign tx_clk = clk;
  assign rx_clk = clk;

  img_tx_rdseq #(.ADDR_W(ADDR_W)) u_rdseq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (accept),
    .count       (cmd_count),
    .addr        (sram_addr),
    .re          (sram_re),
    .issue_first (issue_first),
    .issue_last  (issue_last)
  );

  // flags travel alongside the SRAM read latency
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_v     <= 1'b0;
      ret_first <= 1'b0;
      ret_last  <= 1'b0;
    end else begin
      ret_v     <= sram_re;
      ret_first <= issue_first;
      ret_last  <= issue_last;
    end
  end

  img_tx_fmt #(.DATA_W(DATA_W)) u_fmt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_v     (ret_v),
    .ret_first (ret_first),
    .ret_last  (ret_last),
    .rdata     (sram_rdata),
    .word      (ser_data),
    .word_v    (ser_valid),
    .word_last (word_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= word_last;
      if (accept)         busy <= 1'b1;
      else if (word_last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/img_tx_ctrl_chk.sv
module img_tx_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8,
  localparam int CNT_W  = ADDR_W + 1,
  localparam int WORD_W = DATA_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic [CNT_W-1:0]  cmd_count,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_re,
  input logic [WORD_W-1:0] ser_data,
  input logic              ser_valid,
  input logic              busy,
  input logic              done
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5
  word_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> busy);
  // R3
  read_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_re |-> busy);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_re && $past(sram_re)) |-> (sram_addr == $past(sram_addr) + 1'b1));
  // R4
  tag_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> (ser_data[WORD_W-1 -: 2] == 2'b10 || ser_data[WORD_W-1 -: 2] == 2'b01));
  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start && cmd_count != '0) |=> (busy && sram_re && sram_addr == '0));
  // R8
  zero_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start && cmd_count == '0) |=> !busy);
endmodule

bind img_tx_ctrl img_tx_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .cmd_count (cmd_count),
  .sram_addr (sram_addr),
  .sram_re   (sram_re),
  .ser_data  (ser_data),
  .ser_valid (ser_valid),
  .busy      (busy),
  .done      (done)
);

// File: tb/img_tx_ctrl_tb.sv
module img_tx_ctrl_tb;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int CNT_W  = ADDR_W + 1;
  localparam int WORD_W = DATA_W + 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [CNT_W-1:0]  cmd_count = '0;
  logic [ADDR_W-1:0] sram_addr;
  logic sram_re;
  logic [DATA_W-1:0] sram_rdata = '0;
  logic [WORD_W-1:0] ser_data;
  logic ser_valid, tx_clk, rx_clk, busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  logic [DATA_W-1:0] mem [DEPTH];

  always #2.5 clk = ~clk;

  img_tx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_count(cmd_count),
    .sram_addr(sram_addr), .sram_re(sram_re), .sram_rdata(sram_rdata),
    .ser_data(ser_data), .ser_valid(ser_valid), .tx_clk(tx_clk), .rx_clk(rx_clk),
    .busy(busy), .done(done)
  );

  // synchronous SRAM model, one-cycle read latency
  always @(posedge clk) if (sram_re) sram_rdata <= mem[sram_addr];

  function automatic logic [WORD_W-1:0] exp_word(int k);
    logic [1:0] t;
    t = (k == 0) ? 2'b10 : 2'b01;
    return {t, mem[k % DEPTH]};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one transfer; optionally pokes a start in the middle
  task automatic run(int n, bit poke);
    @(negedge clk);
    cmd_start = 1'b1; cmd_count = CNT_W'(n);
    @(negedge clk);
    cmd_start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(sram_re == 1'b1 && sram_addr == '0, "R2", "first addr", int'(sram_addr), 0);
    for (int c = 1; c <= n + 2; c++) begin
      if (poke && c == 3) begin cmd_start = 1'b1; cmd_count = CNT_W'(5); end
      @(negedge clk);
      if (poke && c == 3) cmd_start = 1'b0;
      chk(sram_re == (c < n), "R3", "sram_re", sram_re, int'(c < n));
      if (c < n)
        chk(sram_addr == ADDR_W'(c % DEPTH), "R3", "sram_addr", int'(sram_addr), c % DEPTH);
      chk(ser_valid == (c >= 2 && c <= n + 1), "R5", "ser_valid", ser_valid,
          int'(c >= 2 && c <= n + 1));
      if (c >= 2 && c <= n + 1)
        chk(ser_data == exp_word(c - 2), "R4", "word", int'(ser_data), int'(exp_word(c - 2)));
      chk(done == (c == n + 2), "R6", "done", done, int'(c == n + 2));
      chk(busy == (c < n + 2), poke ? "R7" : "R6", "busy", busy, int'(c < n + 2));
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R6", "done width", done, 0);
  endtask

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1", "busy/done", {busy, done}, 0);
    chk(sram_re == 0 && ser_valid == 0, "R1", "re/valid", {sram_re, ser_valid}, 0);
    chk(ser_data == '0, "R1", "ser_data", int'(ser_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 shared clocks, both phases
    chk(tx_clk === clk && rx_clk === clk, "R9", "clocks low", tx_clk, clk);
    @(posedge clk); #1;
    chk(tx_clk === clk && rx_clk === clk, "R9", "clocks high", rx_clk, clk);
    // R8 zero count ignored
    @(negedge clk);
    cmd_start = 1'b1; cmd_count = '0;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(busy == 0 && sram_re == 0, "R8", "zero count", {busy, sram_re}, 0);
    @(negedge clk);
    chk(busy == 0 && ser_valid == 0, "R8", "zero count later", {busy, ser_valid}, 0);
    // directed corners
    run(1, 0);
    run(2, 0);
    run(DEPTH, 0);
    run(DEPTH + 6, 0);          // R3 address wrap
    run((1 << CNT_W) - 1, 0);   // largest count
    run(10, 1);                 // R7 start while busy
    // random counts
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'($urandom);
      run(1 + int'($urandom % ((1 << CNT_W) - 1)), ($urandom % 2) == 1);
    end
    finish_run();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected end", cycles);
      finish_run();
    end
  end
endmodule